// File: doc/BRIEF.md
# Receive/Transmit DMA Request Arbiter with Admission Checks

This block picks one of two DMA requesters, a receive channel and a transmit channel, and hands the winner a grant toward the bus master. Each requester presents a host byte address, a transfer size in bytes and a direction flag (write toward the host or read from it). Two software preference bits set the priority. When they disagree, the preferred side wins. When they agree, the two sides alternate. A dynamic override treats the receive side as preferred while the receive FIFO level is above a programmable threshold. This lowers the risk of a FIFO overrun.

The block holds a DMA enable flag that gates all arbitration, alongside a global bus-master enable input. Before a grant is issued, the winning request is checked. A transfer that would run past the top of the 4 GiB address space is refused. So is a write whose address is not word aligned or whose size is not a whole number of 4-word blocks. A refused request receives a one-cycle error pulse, and the enable flag clears. In single-transfer mode the enable flag also clears when a granted transfer completes. Software sets the flag again with a write strobe.

The controller has five states:
- `S_IDLE`: waits for a request.
- `S_GNT_RX` and `S_GNT_TX`: a grant is held.
- `S_REJ_RX` and `S_REJ_TX`: a one-cycle refusal.

The transitions are:
- IDLE to GNT_x: enabled, and the winner passes its checks.
- IDLE to REJ_x: enabled, and the winner fails.
- GNT_x to IDLE: on `xfer_done`.
- REJ_x to IDLE: always, after one cycle.

Top module: `dma_req_arbiter`

## Requirements
- R1: When the effective receive preference is 1 and `cfg_pref_tx` is 0, a pending receive request is chosen over a pending transmit request.
- R2: When `cfg_pref_tx` is 1 and the effective receive preference is 0, a pending transmit request is chosen over a pending receive request.
- R3: When the effective receive preference and `cfg_pref_tx` are equal, simultaneous requests alternate. The side not served by the last completed grant wins. Receive wins first after reset. The turn changes only when a grant completes.
- R4: The effective receive preference is `cfg_pref_rx` OR (`rx_fifo_lvl` > `rx_fifo_thr`). A level equal to the threshold does not force it.
- R5: No grant or error is issued while `dma_en` is 0 or `glb_master_en` is 0. The request is served once both are 1.
- R6: `dma_en` is 1 after reset. A cycle with `en_set` high sets it to 1 on the next edge. A hardware clear in the same cycle takes precedence over `en_set`.
- R7: A winning request of either direction whose address plus size exceeds 2^32 produces a one-cycle error pulse (`rx_err` or `tx_err`) instead of a grant, and clears `dma_en`. A sum exactly equal to 2^32 is accepted.
- R8: A winning write (`*_wr`=1) with address bits [1:0] not zero, or size bits [3:0] not zero (size in bytes), is refused as in R7. A read with the same fields is granted.
- R9: With `cfg_single` at 1, `dma_en` is 0 after the edge on which a granted transfer completes (`xfer_done` high during the grant).
- R10: A grant or error rises on the first clock edge at which an enabled request is seen in the idle state. A grant stays high until the edge on which `xfer_done` is seen. Only the winner is checked, so a malformed losing request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_req | input | 1 | Receive channel requests a transfer |
| rx_addr | input | ADDR_W | Receive host byte address |
| rx_size | input | SIZE_W | Receive transfer size in bytes |
| rx_wr | input | 1 | Receive transfer writes to host |
| tx_req | input | 1 | Transmit channel requests a transfer |
| tx_addr | input | ADDR_W | Transmit host byte address |
| tx_size | input | SIZE_W | Transmit transfer size in bytes |
| tx_wr | input | 1 | Transmit transfer writes to host |
| cfg_pref_rx | input | 1 | Software receive preference |
| cfg_pref_tx | input | 1 | Software transmit preference |
| cfg_single | input | 1 | Single-transfer mode |
| glb_master_en | input | 1 | Global bus-master enable |
| en_set | input | 1 | Write strobe that sets the DMA enable flag |
| rx_fifo_lvl | input | LVL_W | Receive FIFO occupancy |
| rx_fifo_thr | input | LVL_W | Receive preference override threshold |
| xfer_done | input | 1 | Current granted transfer completes |
| rx_gnt | output | 1 | Grant to receive channel |
| tx_gnt | output | 1 | Grant to transmit channel |
| rx_err | output | 1 | One-cycle refusal of a receive request |
| tx_err | output | 1 | One-cycle refusal of a transmit request |
| dma_en | output | 1 | DMA enable flag |

## Verification
The checker watches every cycle for four things: grants that start while gating is off, grants that start on a request crossing the 4 GiB top, grants on a misaligned write, and a transmit grant taken from a pending preferred receive request. It also checks that a grant holds until completion, that an error always leaves the enable flag clear, and that single-mode completion clears the flag. Some behaviour depends on history and can only be shown by the bench's scenarios. This includes the alternating order and where it starts after reset, the equal-threshold case of the override, the precedence of the hardware clear over `en_set`, and the recovery through the write strobe.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_GNT_RX = 3'd1,
        S_GNT_TX = 3'd2,
        S_REJ_RX = 3'd3,
        S_REJ_TX = 3'd4
    } arb_state_e;

    typedef enum logic {
        CH_RX = 1'b0,
        CH_TX = 1'b1
    } chan_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/dma_adm_check.sv
module dma_adm_check #(
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 16,
    parameter int WORD_BYTES  = 4,
    parameter int BLOCK_WORDS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              wr,
    output logic              ok
);
    localparam int WB_LSB  = $clog2(WORD_BYTES);
    localparam int BLK_LSB = $clog2(WORD_BYTES * BLOCK_WORDS);
    localparam logic [ADDR_W:0] SPACE_TOP = {1'b1, {ADDR_W{1'b0}}};

    logic [ADDR_W:0] end_addr;
    logic            past_top;
    logic            bad_align;

    always_comb begin
        end_addr  = {1'b0, addr} + (ADDR_W+1)'(size);
        past_top  = end_addr > SPACE_TOP;
        bad_align = wr && ((addr[WB_LSB-1:0] != '0) || (size[BLK_LSB-1:0] != '0));
        ok        = !past_top && !bad_align;
    end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
    import dma_arb_pkg::*;
(
    input  logic  pref_rx,
    input  logic  pref_tx,
    input  logic  rx_req,
    input  logic  tx_req,
    input  chan_e rr_last,
    output logic  win_valid,
    output chan_e win
);
    always_comb begin
        win_valid = rx_req || tx_req;
        win       = CH_RX;
        if (rx_req && tx_req) begin
            if (pref_rx && !pref_tx) begin
                win = CH_RX;
            end else if (pref_tx && !pref_rx) begin
                win = CH_TX;
            end else begin
                win = (rr_last == CH_RX) ? CH_TX : CH_RX;
            end
        end else if (tx_req) begin
            win = CH_TX;
        end
    end

endmodule

// File: rtl/dma_en_ctl.sv
module dma_en_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_clr,
    input  logic sw_set,
    output logic en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b1;
        end else if (hw_clr) begin
            en <= 1'b0;
        end else if (sw_set) begin
            en <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 16,
    parameter int LVL_W       = 6,
    parameter int WORD_BYTES  = 4,
    parameter int BLOCK_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_req,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [SIZE_W-1:0] rx_size,
    input  logic              rx_wr,
    input  logic              tx_req,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic [SIZE_W-1:0] tx_size,
    input  logic              tx_wr,
    input  logic              cfg_pref_rx,
    input  logic              cfg_pref_tx,
    input  logic              cfg_single,
    input  logic              glb_master_en,
    input  logic              en_set,
    input  logic [LVL_W-1:0]  rx_fifo_lvl,
    input  logic [LVL_W-1:0]  rx_fifo_thr,
    input  logic              xfer_done,
    output logic              rx_gnt,
    output logic              tx_gnt,
    output logic              rx_err,
    output logic              tx_err,
    output logic              dma_en
);
    arb_state_e state_q, state_d;
    chan_e      rr_last_q;

    logic [ADDR_W-1:0] ch_addr [NUM_CH];
    logic [SIZE_W-1:0] ch_size [NUM_CH];
    logic [NUM_CH-1:0] ch_wr;
    logic [NUM_CH-1:0] ch_ok;

    logic  fifo_hot;
    logic  eff_pref_rx;
    logic  allow;
    logic  win_valid;
    chan_e win;
    logic  win_ok;
    logic  in_grant;
    logic  grant_end;
    logic  reject_now;
    logic  hw_clr;

    assign ch_addr[0] = rx_addr;
    assign ch_addr[1] = tx_addr;
    assign ch_size[0] = rx_size;
    assign ch_size[1] = tx_size;
    assign ch_wr      = {tx_wr, rx_wr};

    // One admission checker per channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        dma_adm_check #(
            .ADDR_W      (ADDR_W),
            .SIZE_W      (SIZE_W),
            .WORD_BYTES  (WORD_BYTES),
            .BLOCK_WORDS (BLOCK_WORDS)
        ) u_adm (
            .addr (ch_addr[g]),
            .size (ch_size[g]),
            .wr   (ch_wr[g]),
            .ok   (ch_ok[g])
        );
    end

    assign fifo_hot    = rx_fifo_lvl > rx_fifo_thr;
    assign eff_pref_rx = cfg_pref_rx || fifo_hot;
    assign allow       = dma_en && glb_master_en;

    dma_prio_pick u_pick (
        .pref_rx   (eff_pref_rx),
        .pref_tx   (cfg_pref_tx),
        .rx_req    (rx_req),
        .tx_req    (tx_req),
        .rr_last   (rr_last_q),
        .win_valid (win_valid),
        .win       (win)
    );

    assign win_ok     = (win == CH_TX) ? ch_ok[1] : ch_ok[0];
    assign in_grant   = (state_q == S_GNT_RX) || (state_q == S_GNT_TX);
    assign grant_end  = in_grant && xfer_done;
    assign reject_now = (state_q == S_IDLE) && allow && win_valid && !win_ok;
    assign hw_clr     = reject_now || (grant_end && cfg_single);

    dma_en_ctl u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_clr (hw_clr),
        .sw_set (en_set),
        .en     (dma_en)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (allow && win_valid) begin
                    if (win == CH_TX) begin
                        state_d = win_ok ? S_GNT_TX : S_REJ_TX;
                    end else begin
                        state_d = win_ok ? S_GNT_RX : S_REJ_RX;
                    end
                end
            end
            S_GNT_RX, S_GNT_TX: begin
                if (xfer_done) begin
                    state_d = S_IDLE;
                end
            end
            S_REJ_RX, S_REJ_TX: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Turn pointer: moves only when a grant completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_last_q <= CH_TX;
        end else if (grant_end) begin
            rr_last_q <= (state_q == S_GNT_TX) ? CH_TX : CH_RX;
        end
    end

    // Outputs decoded from state
    always_comb begin
        rx_gnt = 1'b0;
        tx_gnt = 1'b0;
        rx_err = 1'b0;
        tx_err = 1'b0;
        unique case (state_q)
            S_GNT_RX: rx_gnt = 1'b1;
            S_GNT_TX: tx_gnt = 1'b1;
            S_REJ_RX: rx_err = 1'b1;
            S_REJ_TX: tx_err = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 16,
    parameter int LVL_W       = 6,
    parameter int WORD_BYTES  = 4,
    parameter int BLOCK_WORDS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_req,
    input logic [ADDR_W-1:0] rx_addr,
    input logic [SIZE_W-1:0] rx_size,
    input logic              rx_wr,
    input logic [ADDR_W-1:0] tx_addr,
    input logic [SIZE_W-1:0] tx_size,
    input logic              tx_wr,
    input logic              cfg_pref_rx,
    input logic              cfg_pref_tx,
    input logic              cfg_single,
    input logic              glb_master_en,
    input logic [LVL_W-1:0]  rx_fifo_lvl,
    input logic [LVL_W-1:0]  rx_fifo_thr,
    input logic              xfer_done,
    input logic              rx_gnt,
    input logic              tx_gnt,
    input logic              rx_err,
    input logic              tx_err,
    input logic              dma_en
);
    localparam int WB_LSB  = $clog2(WORD_BYTES);
    localparam int BLK_LSB = $clog2(WORD_BYTES * BLOCK_WORDS);
    localparam logic [ADDR_W:0] SPACE_TOP = {1'b1, {ADDR_W{1'b0}}};

    // R1
    rx_pref_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_gnt) |-> !$past(rx_req && !cfg_pref_tx &&
                                 (cfg_pref_rx || (rx_fifo_lvl > rx_fifo_thr))));

    // R5
    gated_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_gnt) || $rose(tx_gnt)) |-> $past(dma_en && glb_master_en));

    // R7
    rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_gnt) |-> (({1'b0, $past(rx_addr)} + (ADDR_W+1)'($past(rx_size))) <= SPACE_TOP));

    // R7
    tx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_gnt) |-> (({1'b0, $past(tx_addr)} + (ADDR_W+1)'($past(tx_size))) <= SPACE_TOP));

    // R8
    rx_aligned_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_gnt) && $past(rx_wr)) |->
            ($past(rx_addr[WB_LSB-1:0]) == '0 && $past(rx_size[BLK_LSB-1:0]) == '0));

    // R8
    tx_aligned_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_gnt) && $past(tx_wr)) |->
            ($past(tx_addr[WB_LSB-1:0]) == '0 && $past(tx_size[BLK_LSB-1:0]) == '0));

    // R6
    err_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err || tx_err) |-> !dma_en);

    // R9
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_single && (rx_gnt || tx_gnt) && xfer_done) |=> !dma_en);

    // R10
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_gnt && !xfer_done) |=> rx_gnt);

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_gnt && !xfer_done) |=> tx_gnt);

endmodule

bind dma_req_arbiter dma_arb_chk #(
    .ADDR_W      (ADDR_W),
    .SIZE_W      (SIZE_W),
    .LVL_W       (LVL_W),
    .WORD_BYTES  (WORD_BYTES),
    .BLOCK_WORDS (BLOCK_WORDS)
) u_chk (.*);

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;

    typedef struct packed {
        logic        prx;
        logic        ptx;
        logic [5:0]  lvl;
        logic        rxr;
        logic        txr;
        logic [31:0] ra;
        logic [15:0] rs;
        logic        rw;
        logic [31:0] ta;
        logic [15:0] ts;
        logic        tw;
        logic [3:0]  exp;   // {rx_gnt, tx_gnt, rx_err, tx_err}
    } vec_t;

    localparam int NV = 15;
    localparam logic [3:0] E_RX  = 4'b1000;
    localparam logic [3:0] E_TX  = 4'b0100;
    localparam logic [3:0] E_ERX = 4'b0010;
    localparam logic [3:0] E_ETX = 4'b0001;

    localparam vec_t VT [NV] = '{
        '{1'b1,1'b0,6'd3,1'b1,1'b1,32'h0000_1000,16'h0040,1'b1,32'h0000_2000,16'h0080,1'b1,E_RX },
        '{1'b0,1'b1,6'd3,1'b1,1'b1,32'h0000_1000,16'h0040,1'b1,32'h0000_2000,16'h0080,1'b1,E_TX },
        '{1'b0,1'b0,6'd3,1'b1,1'b1,32'h0000_1000,16'h0040,1'b1,32'h0000_2000,16'h0080,1'b1,E_RX },
        '{1'b0,1'b0,6'd3,1'b1,1'b1,32'h0000_1000,16'h0040,1'b1,32'h0000_2000,16'h0080,1'b1,E_TX },
        '{1'b1,1'b1,6'd3,1'b1,1'b1,32'h0000_1000,16'h0040,1'b1,32'h0000_2000,16'h0080,1'b1,E_RX },
        '{1'b0,1'b1,6'd9,1'b1,1'b1,32'h0000_1000,16'h0040,1'b1,32'h0000_2000,16'h0080,1'b1,E_TX },
        '{1'b0,1'b0,6'd9,1'b1,1'b1,32'h0000_1000,16'h0040,1'b1,32'h0000_2000,16'h0080,1'b1,E_RX },
        '{1'b1,1'b0,6'd3,1'b0,1'b1,32'h0000_1000,16'h0040,1'b1,32'h0000_2000,16'h0080,1'b1,E_TX },
        '{1'b1,1'b0,6'd3,1'b1,1'b0,32'hFFFF_FFF0,16'h0020,1'b0,32'h0000_2000,16'h0080,1'b1,E_ERX},
        '{1'b1,1'b0,6'd3,1'b1,1'b0,32'hFFFF_FFE0,16'h0020,1'b1,32'h0000_2000,16'h0080,1'b1,E_RX },
        '{1'b0,1'b0,6'd8,1'b1,1'b1,32'h0000_1000,16'h0040,1'b1,32'h0000_2000,16'h0080,1'b1,E_TX },
        '{1'b0,1'b0,6'd3,1'b0,1'b1,32'h0000_1000,16'h0040,1'b1,32'h0000_2002,16'h0080,1'b1,E_ETX},
        '{1'b0,1'b0,6'd3,1'b0,1'b1,32'h0000_1000,16'h0040,1'b1,32'h0000_2002,16'h0013,1'b0,E_TX },
        '{1'b1,1'b0,6'd3,1'b1,1'b0,32'h0000_1000,16'h0018,1'b1,32'h0000_2000,16'h0080,1'b1,E_ERX},
        '{1'b0,1'b1,6'd3,1'b1,1'b1,32'h0000_1002,16'h0040,1'b1,32'h0000_2000,16'h0080,1'b1,E_TX }
    };

    string vtag [NV] = '{"R1","R2","R3","R3","R3","R4","R4","R1",
                         "R7","R7","R4","R8","R8","R8","R10"};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_req, tx_req, rx_wr, tx_wr;
    logic [31:0] rx_addr, tx_addr;
    logic [15:0] rx_size, tx_size;
    logic        cfg_pref_rx, cfg_pref_tx, cfg_single, glb_master_en, en_set;
    logic [5:0]  rx_fifo_lvl, rx_fifo_thr;
    logic        xfer_done;
    logic        rx_gnt, tx_gnt, rx_err, tx_err, dma_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_req_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .rx_req(rx_req), .rx_addr(rx_addr), .rx_size(rx_size), .rx_wr(rx_wr),
        .tx_req(tx_req), .tx_addr(tx_addr), .tx_size(tx_size), .tx_wr(tx_wr),
        .cfg_pref_rx(cfg_pref_rx), .cfg_pref_tx(cfg_pref_tx), .cfg_single(cfg_single),
        .glb_master_en(glb_master_en), .en_set(en_set),
        .rx_fifo_lvl(rx_fifo_lvl), .rx_fifo_thr(rx_fifo_thr),
        .xfer_done(xfer_done),
        .rx_gnt(rx_gnt), .tx_gnt(tx_gnt), .rx_err(rx_err), .tx_err(tx_err),
        .dma_en(dma_en)
    );

    task automatic chk(input string tag, input string what, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {rx_gnt, tx_gnt, rx_err, tx_err};
    endfunction

    task automatic idle_inputs();
        rx_req = 1'b0; tx_req = 1'b0;
        rx_addr = 32'h0000_1000; rx_size = 16'h0040; rx_wr = 1'b1;
        tx_addr = 32'h0000_2000; tx_size = 16'h0080; tx_wr = 1'b1;
        cfg_pref_rx = 1'b0; cfg_pref_tx = 1'b0;
        rx_fifo_lvl = 6'd3;
    endtask

    task automatic finish_grant(input logic with_set);
        xfer_done = 1'b1; en_set = with_set;
        rx_req = 1'b0; tx_req = 1'b0;
        @(negedge clk);
        xfer_done = 1'b0; en_set = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        cfg_single = 1'b0; glb_master_en = 1'b1; en_set = 1'b0;
        rx_fifo_thr = 6'd8; xfer_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset value, R10 no outputs in idle
        chk("R6", "reset enable", {3'b0, dma_en}, 4'b0001);
        chk("R10", "reset outputs", outs(), 4'b0000);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            cfg_pref_rx = VT[i].prx; cfg_pref_tx = VT[i].ptx;
            rx_fifo_lvl = VT[i].lvl;
            rx_req = VT[i].rxr; tx_req = VT[i].txr;
            rx_addr = VT[i].ra; rx_size = VT[i].rs; rx_wr = VT[i].rw;
            tx_addr = VT[i].ta; tx_size = VT[i].ts; tx_wr = VT[i].tw;
            @(negedge clk);
            chk(vtag[i], $sformatf("vector %0d outputs", i), outs(), VT[i].exp);
            if (VT[i].exp[3] || VT[i].exp[2]) begin
                finish_grant(1'b0);
            end else begin
                chk(vtag[i], $sformatf("vector %0d enable after refusal", i), {3'b0, dma_en}, 4'b0000);
                rx_req = 1'b0; tx_req = 1'b0; en_set = 1'b1;
                @(negedge clk);
                en_set = 1'b0;
                chk("R6", $sformatf("vector %0d enable restored", i), {3'b0, dma_en}, 4'b0001);
            end
            idle_inputs();
            @(negedge clk);
        end

        // R5: global enable low blocks the grant
        glb_master_en = 1'b0; rx_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5", "global enable off", outs(), 4'b0000);
        glb_master_en = 1'b1;
        @(negedge clk);
        chk("R5", "global enable on", outs(), E_RX);
        // R10: grant held while completion absent
        repeat (3) @(negedge clk);
        chk("R10", "grant held", outs(), E_RX);
        finish_grant(1'b0);
        chk("R10", "grant released", outs(), 4'b0000);
        @(negedge clk);

        // R5: enable flag low blocks the grant
        rx_req = 1'b1; rx_addr = 32'hFFFF_FFC0; rx_size = 16'h0080;
        @(negedge clk);
        chk("R7", "overflow refused", outs(), E_ERX);
        rx_addr = 32'h0000_1000; rx_size = 16'h0040;
        repeat (2) @(negedge clk);
        chk("R5", "enable off blocks", outs(), 4'b0000);
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        @(negedge clk);
        chk("R5", "served after set", outs(), E_RX);
        finish_grant(1'b0);
        @(negedge clk);

        // R9: single mode completion clears enable
        cfg_single = 1'b1; tx_req = 1'b1;
        @(negedge clk);
        chk("R9", "single grant", outs(), E_TX);
        finish_grant(1'b0);
        chk("R9", "enable cleared", {3'b0, dma_en}, 4'b0000);
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        chk("R6", "set after single", {3'b0, dma_en}, 4'b0001);

        // R6: hardware clear wins over simultaneous set
        rx_req = 1'b1;
        @(negedge clk);
        chk("R9", "single grant rx", outs(), E_RX);
        finish_grant(1'b1);
        chk("R6", "clear beats set", {3'b0, dma_en}, 4'b0000);
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        chk("R6", "set alone", {3'b0, dma_en}, 4'b0001);
        cfg_single = 1'b0;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule